// File: doc/BRIEF.md
# Byte-Interleaved Transmit Stream Demultiplexer

This block accepts one high-rate serial stream in which four T1 transmit channels are interleaved octet by octet. A second serial line carries signaling bits in step with the data, and a frame-sync input marks where each multiplexed frame begins. The block locks its bit position to the sync pulse and drops the periodic filler octets. Every payload octet is handed out on a single output bus, tagged with its channel and timeslot, together with the four signaling bits that travelled alongside it.

A frame holds 24 timeslots per channel. They are sent as eight groups, and each group contains three timeslots for channels 0 to 3 in turn (12 octets). Eight filler octets follow every group. The sync input has two shapes, selected by a mode pin. The wide shape is high for four cycles, and the frame begins on the third of them. The narrow shape is high for two cycles, and the frame begins on the second. Once the block is locked, a pulse that lands on the expected boundary changes nothing. A pulse anywhere else raises a one-cycle flag and moves the lock to the new pulse.

Top module: `tbm_txmux_demux`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` and `misalign` stay 0 until a frame start has been seen. Data on `sdata`/`ssig` with no sync pulse produces no output.
- R2: With `sync_wide` = 1, the cycle in which `fsync` is high for the third consecutive time carries payload bit 1 of channel 0, timeslot 0.
- R3: With `sync_wide` = 0, the cycle in which `fsync` is high for the second consecutive time carries payload bit 1 of channel 0, timeslot 0.
- R4: Within a group, octet k (k = 0..11) goes to channel k mod 4 and to timeslot 3·g + k/4, where g is the group number (0..7). `out_chan` and `out_slot` report these values.
- R5: Each payload octet is received MSB first: the first bit of the octet on `sdata` becomes `out_data[7]`.
- R6: The values on `ssig` during payload bits 5, 6, 7 and 8 of an octet are reported as `out_sig[3]`, `out_sig[2]`, `out_sig[1]` and `out_sig[0]` (signaling A, B, C, D).
- R7: The eight octets that follow each group of 12 payload octets never produce `out_valid`, whatever their content.
- R8: `out_valid` is high for exactly one cycle. That cycle immediately follows the cycle that carried bit 8 of a payload octet, and the data, signaling, channel and slot fields are valid in that same cycle.
- R9: While locked, a sync pulse whose frame start falls on the expected boundary leaves `misalign` low and does not disturb the output sequence.
- R10: A frame start at any other position raises `misalign` for one cycle, in the cycle after that start. The block then decodes from the new start.
- R11: `ssig` during payload bits 1 to 4 and during filler octets has no effect on `out_sig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the multiplexed stream |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_wide | input | 1 | 1: four-cycle sync shape; 0: two-cycle sync shape |
| fsync | input | 1 | Frame-sync pulse straddling the frame boundary |
| sdata | input | 1 | Multiplexed payload and filler bits |
| ssig | input | 1 | Signaling bits in step with payload bits 5 to 8 |
| out_valid | output | 1 | One-cycle strobe for a completed payload octet |
| out_chan | output | 2 | Channel number 0 to 3 |
| out_slot | output | 5 | Timeslot number 0 to 23 |
| out_data | output | 8 | Payload octet, first received bit in bit 7 |
| out_sig | output | 4 | Signaling nibble A..D in bits 3..0 |
| misalign | output | 1 | One-cycle flag for a sync pulse off the expected boundary |

## Verification
Every result comes from one register stage. An octet shows up one cycle after the cycle that carried its eighth bit, and the misalignment flag shows up one cycle after the frame-start cycle. The bench drives each bit on a falling edge. At the next falling edge it compares the outputs against the expectation it stored for the bit driven one step earlier. Because of this, every cycle is checked, including the filler octets and the cycles before lock, where the expected strobe is 0. Frames are built from computed payload and signaling values with random filler and random idle signaling, in both sync shapes. A deliberately shifted pulse then exercises the realignment path.

// File: rtl/tbm_pkg.sv
// Package tbm_pkg
// Shared constants and the sync-shape encoding for the transmit stream
// demultiplexer. Assumes octets of eight bits and four signaling bits.
package tbm_pkg;
    localparam int OCT_BITS  = 8;
    localparam int SIG_BITS  = 4;

    typedef enum logic {
        SYNC_NARROW = 1'b0,
        SYNC_WIDE   = 1'b1
    } sync_shape_e;
endpackage

// File: rtl/tbm_sync_det.sv
// Module tbm_sync_det
// Counts consecutive high cycles of the frame-sync input and marks the cycle
// that holds the first bit of a frame: the third high cycle for the wide
// shape, the second for the narrow one. Assumes pulses are separated by at
// least one low cycle.
module tbm_sync_det
    import tbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic sync_wide,
    output logic frame_start
);
    logic [2:0]  run_q;
    logic [2:0]  start_idx;
    sync_shape_e shape;

    assign shape       = sync_shape_e'(sync_wide);
    assign start_idx   = (shape == SYNC_WIDE) ? 3'd2 : 3'd1;
    assign frame_start = fsync && (run_q == start_idx);

    // Track how many cycles the sync input has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= 3'd0;
        else if (!fsync)       run_q <= 3'd0;
        else if (run_q != 3'd7) run_q <= run_q + 3'd1;
    end
endmodule

// File: rtl/tbm_frame_pos.sv
// Module tbm_frame_pos
// Holds the bit, octet-in-group and group position of the current cycle
// within a multiplexed frame. A frame start forces the position to zero;
// a start while already locked at a non-zero position is reported as a
// misalignment. Assumes the frame is NGRP groups of payload plus filler.
module tbm_frame_pos #(
    parameter int NCH       = 4,
    parameter int SLOTS_GRP = 3,
    parameter int NGRP      = 8,
    parameter int STUFF_OCT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    output logic                 active,
    output logic                 misalign_c,
    output logic [2:0]           bit_idx,
    output logic [$clog2(NCH*SLOTS_GRP+STUFF_OCT)-1:0] oct_idx,
    output logic [((NGRP > 1) ? $clog2(NGRP) : 1)-1:0] grp_idx
);
    localparam int GRP_OCT = NCH * SLOTS_GRP + STUFF_OCT;
    localparam int OCTW    = $clog2(GRP_OCT);
    localparam int GRPW    = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic            locked_q;
    logic [2:0]      bit_q;
    logic [OCTW-1:0] oct_q;
    logic [GRPW-1:0] grp_q;

    assign active     = locked_q || frame_start;
    assign bit_idx    = frame_start ? 3'd0 : bit_q;
    assign oct_idx    = frame_start ? '0 : oct_q;
    assign grp_idx    = frame_start ? '0 : grp_q;
    assign misalign_c = frame_start && locked_q &&
                        ((bit_q != 3'd0) || (oct_q != '0) || (grp_q != '0));

    // Lock on the first frame start and keep the lock until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           locked_q <= 1'b0;
        else if (frame_start) locked_q <= 1'b1;
    end

    // Advance the frame position by one bit per active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 3'd0;
            oct_q <= '0;
            grp_q <= '0;
        end else if (active) begin
            bit_q <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
                if (int'(oct_idx) == GRP_OCT - 1) begin
                    oct_q <= '0;
                    grp_q <= (int'(grp_idx) == NGRP - 1) ? '0 : grp_idx + 1'b1;
                end else begin
                    oct_q <= oct_idx + 1'b1;
                    grp_q <= grp_idx;
                end
            end else begin
                oct_q <= oct_idx;
                grp_q <= grp_idx;
            end
        end
    end
endmodule

// File: rtl/tbm_capture.sv
// Module tbm_capture
// Shifts in payload bits MSB first and signaling bits during payload bits
// 5..8. At the last bit of a payload octet it registers octet, nibble,
// channel and slot with a one-cycle strobe. Filler octets are never
// presented. Assumes position inputs describe the current cycle's bit.
module tbm_capture #(
    parameter int NCH       = 4,
    parameter int SLOTS_GRP = 3,
    parameter int NGRP      = 8,
    parameter int STUFF_OCT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 misalign_c,
    input  logic [2:0]           bit_idx,
    input  logic [$clog2(NCH*SLOTS_GRP+STUFF_OCT)-1:0] oct_idx,
    input  logic [((NGRP > 1) ? $clog2(NGRP) : 1)-1:0] grp_idx,
    input  logic                 sdata,
    input  logic                 ssig,
    output logic                 out_valid,
    output logic [$clog2(NCH)-1:0] out_chan,
    output logic [$clog2(NGRP*SLOTS_GRP)-1:0] out_slot,
    output logic [7:0]           out_data,
    output logic [3:0]           out_sig,
    output logic                 misalign
);
    localparam int PAY_OCT = NCH * SLOTS_GRP;
    localparam int CHW     = $clog2(NCH);
    localparam int SLOTW   = $clog2(NGRP * SLOTS_GRP);

    logic [6:0] data_sh;
    logic [2:0] sig_sh;
    logic       is_pay;
    logic       last_bit;
    logic       sig_bit;

    assign is_pay   = int'(oct_idx) < PAY_OCT;
    assign last_bit = active && is_pay && (bit_idx == 3'd7);
    assign sig_bit  = active && is_pay && (bit_idx >= 3'd4);

    // Shift payload bits in, first bit ending up at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_sh <= '0;
        else if (active) data_sh <= {data_sh[5:0], sdata};
    end

    // Shift signaling bits in only while payload bits 5..8 are on the line.
    always_ff @(posedge clk) begin
        if (!rst_n)       sig_sh <= '0;
        else if (sig_bit) sig_sh <= {sig_sh[1:0], ssig};
    end

    // Present a completed payload octet with its tags for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_slot  <= '0;
            out_data  <= '0;
            out_sig   <= '0;
        end else begin
            out_valid <= last_bit;
            if (last_bit) begin
                out_data <= {data_sh, sdata};
                out_sig  <= {sig_sh, ssig};
                out_chan <= CHW'(int'(oct_idx) % NCH);
                out_slot <= SLOTW'(int'(grp_idx) * SLOTS_GRP + int'(oct_idx) / NCH);
            end
        end
    end

    // Register the misalignment indication alongside the data outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) misalign <= 1'b0;
        else        misalign <= misalign_c;
    end
endmodule

// File: rtl/tbm_txmux_demux.sv
// Module tbm_txmux_demux
// Top of the byte-interleaved transmit stream demultiplexer: sync
// detection, frame position tracking and octet capture. Assumes the sender
// aligns the data stream to the sync pulse it provides.
module tbm_txmux_demux #(
    parameter int NCH       = 4,
    parameter int SLOTS_GRP = 3,
    parameter int NGRP      = 8,
    parameter int STUFF_OCT = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sync_wide,
    input  logic                              fsync,
    input  logic                              sdata,
    input  logic                              ssig,
    output logic                              out_valid,
    output logic [$clog2(NCH)-1:0]            out_chan,
    output logic [$clog2(NGRP*SLOTS_GRP)-1:0] out_slot,
    output logic [7:0]                        out_data,
    output logic [3:0]                        out_sig,
    output logic                              misalign
);
    localparam int OCTW = $clog2(NCH * SLOTS_GRP + STUFF_OCT);
    localparam int GRPW = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic            frame_start;
    logic            active;
    logic            misalign_c;
    logic [2:0]      bit_idx;
    logic [OCTW-1:0] oct_idx;
    logic [GRPW-1:0] grp_idx;

    tbm_sync_det u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .sync_wide   (sync_wide),
        .frame_start (frame_start)
    );

    tbm_frame_pos #(
        .NCH(NCH), .SLOTS_GRP(SLOTS_GRP), .NGRP(NGRP), .STUFF_OCT(STUFF_OCT)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .active      (active),
        .misalign_c  (misalign_c),
        .bit_idx     (bit_idx),
        .oct_idx     (oct_idx),
        .grp_idx     (grp_idx)
    );

    tbm_capture #(
        .NCH(NCH), .SLOTS_GRP(SLOTS_GRP), .NGRP(NGRP), .STUFF_OCT(STUFF_OCT)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .misalign_c (misalign_c),
        .bit_idx    (bit_idx),
        .oct_idx    (oct_idx),
        .grp_idx    (grp_idx),
        .sdata      (sdata),
        .ssig       (ssig),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_slot   (out_slot),
        .out_data   (out_data),
        .out_sig    (out_sig),
        .misalign   (misalign)
    );
endmodule

// File: rtl/tbm_txmux_demux_chk.sv
// Module tbm_txmux_demux_chk
// Property checks for tbm_txmux_demux, attached through bind. Relates the
// registered outputs to the position state of the previous cycle.
module tbm_txmux_demux_chk #(
    parameter int NCH       = 4,
    parameter int SLOTS_GRP = 3,
    parameter int NGRP      = 8,
    parameter int STUFF_OCT = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              out_valid,
    input logic [$clog2(NGRP*SLOTS_GRP)-1:0] out_slot,
    input logic                              misalign,
    input logic                              active,
    input logic [2:0]                        bit_idx,
    input logic [$clog2(NCH*SLOTS_GRP+STUFF_OCT)-1:0] oct_idx
);
    localparam int PAY_OCT = NCH * SLOTS_GRP;
    localparam int NSLOT   = NGRP * SLOTS_GRP;

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    stuff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(active) && ($past(bit_idx) == 3'd7) &&
                       (int'($past(oct_idx)) < PAY_OCT)));

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_slot) < NSLOT));

    // R10
    misalign_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !misalign);

    // R1
    locked_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || misalign) |-> $past(active));
endmodule

bind tbm_txmux_demux tbm_txmux_demux_chk #(
    .NCH(NCH), .SLOTS_GRP(SLOTS_GRP), .NGRP(NGRP), .STUFF_OCT(STUFF_OCT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .misalign  (misalign),
    .active    (active),
    .bit_idx   (bit_idx),
    .oct_idx   (oct_idx)
);

// File: tb/tbm_txmux_demux_tb.sv
// Directed bench for tbm_txmux_demux. Bits are driven on falling edges;
// every falling edge compares outputs with the expectation stored for the
// bit driven one cycle earlier.
module tbm_txmux_demux_tb;
    localparam int FL_GRP = 20 * 8;
    localparam int FL     = 8 * FL_GRP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_wide = 1'b1;
    logic       fsync = 1'b0;
    logic       sdata = 1'b0;
    logic       ssig = 1'b0;
    logic       out_valid;
    logic [1:0] out_chan;
    logic [4:0] out_slot;
    logic [7:0] out_data;
    logic [3:0] out_sig;
    logic       misalign;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tbm_txmux_demux u_dut (
        .clk(clk), .rst_n(rst_n), .sync_wide(sync_wide), .fsync(fsync),
        .sdata(sdata), .ssig(ssig), .out_valid(out_valid), .out_chan(out_chan),
        .out_slot(out_slot), .out_data(out_data), .out_sig(out_sig),
        .misalign(misalign)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_val(int f, int c, int s, int seed);
        return 8'((f * 53 + c * 71 + s * 13 + seed) & 255);
    endfunction

    function automatic logic [3:0] sig_val(int f, int c, int s, int seed);
        return 4'((f * 5 + c * 3 + s * 7 + seed) & 15);
    endfunction

    // R1: reset state and no output without a sync pulse.
    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fsync = 1'b1;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(misalign == 1'b0, "R1 flag in reset", int'(misalign), 0);
        fsync = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            sdata = 1'($urandom);
            ssig  = 1'($urandom);
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 valid before sync", int'(out_valid), 0);
            chk(misalign == 1'b0, "R1 flag before sync", int'(misalign), 0);
        end
    endtask

    // R2/R3..R11: stream nfr frames, checking every cycle.
    task automatic run_frames(input bit wide, input int nfr, input bit exp_mis, input int seed);
        bit         ev = 0, em = 0;
        logic [7:0] ed = 0;
        logic [3:0] es = 0;
        int         ec = 0, et = 0;
        string      al;
        al = wide ? "R2" : "R3";
        sync_wide = wide;
        for (int i = -4; i <= nfr * FL + 1; i++) begin
            @(negedge clk);
            // outputs due from the bit driven one cycle earlier
            if (i > -4) begin
                chk(out_valid == ev, ev ? "R8 strobe" : "R7 no output", int'(out_valid), int'(ev));
                if (ev && out_valid) begin
                    chk(out_data == ed, {al, " R5 data"}, int'(out_data), int'(ed));
                    chk(out_sig == es, "R6 R11 signaling", int'(out_sig), int'(es));
                    chk(int'(out_chan) == ec, "R4 channel", int'(out_chan), ec);
                    chk(int'(out_slot) == et, "R4 slot", int'(out_slot), et);
                end
                chk(misalign == em, em ? "R10 misalign" : "R9 no misalign", int'(misalign), int'(em));
            end
            ev = 0;
            em = 0;
            if (i >= nfr * FL) begin
                fsync = 1'b0;
                sdata = 1'($urandom);
                ssig  = 1'($urandom);
            end else begin
                int m;
                m = ((i % FL) + FL) % FL;
                fsync = wide ? (m >= FL - 2 || m <= 1) : (m == FL - 1 || m == 0);
                sdata = 1'($urandom);
                ssig  = 1'($urandom);
                if (i >= 0) begin
                    int f, g, rem, o, b;
                    f   = i / FL;
                    g   = m / FL_GRP;
                    rem = m % FL_GRP;
                    o   = rem / 8;
                    b   = rem % 8;
                    em  = (i == 0) && exp_mis;
                    if (o < 12) begin
                        int c, s;
                        logic [7:0] pb;
                        logic [3:0] nb;
                        c  = o % 4;
                        s  = g * 3 + o / 4;
                        pb = pay_val(f, c, s, seed);
                        nb = sig_val(f, c, s, seed);
                        sdata = pb[7 - b];
                        if (b >= 4) ssig = nb[7 - b];
                        if (b == 7) begin
                            ev = 1; ed = pb; es = nb; ec = c; et = s;
                        end
                    end
                end
            end
        end
    endtask

    initial begin
        test_reset();
        run_frames(1'b1, 2, 1'b0, 11);
        run_frames(1'b1, 1, 1'b1, 29);
        test_reset();
        run_frames(1'b0, 2, 1'b0, 47);
        run_frames(1'b0, 1, 1'b1, 83);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule